// File: doc/BRIEF.md
# Protection-Region CSR Register File

This block holds the programmable state of sixteen memory protection regions inside a processor's machine-mode control/status register space. Each region owns an 8-bit configuration byte and an address register as wide as the machine word. The core's CSR unit presents one access per cycle: a 12-bit CSR number, a write enable and write data. The block answers with the value the register held before the access, and with a flag that marks CSR numbers it does not implement.

Configuration bytes are not reachable one by one. They are packed into word-wide configuration CSRs. A 32-bit machine packs four bytes per CSR and uses four of them. A 64-bit machine packs eight bytes per CSR and implements only the even-numbered two. Every stored byte and address is also driven out in parallel so that a separate access checker can read them. The block only stores these fields and does not interpret them. By convention bit 0 is read permission, bit 1 write, bit 2 execute, bits 4:3 the address-match mode and bit 7 the lock bit. The read-permission bit of each region is also brought out as its own vector.

Top module: `pmp_csr_file`

## Requirements
- R1: After reset every configuration byte, every address register, the read data and the illegal flag are zero.
- R2: With XLEN=32, configuration CSR 0x3A0+k (k=0..3) maps regions 4k..4k+3. Region 4k+j sits in bits [8j+7:8j] on both read and write.
- R3: With XLEN=64, CSR 0x3A0 maps regions 0..7 and CSR 0x3A2 maps regions 8..15. Region i sits in bits [8(i mod 8)+7:8(i mod 8)].
- R4: With XLEN=64, CSR numbers 0x3A1 and 0x3A3 are not implemented. An access to either is flagged illegal, reads zero and changes no configuration byte.
- R5: One write to a configuration CSR updates all the bytes it packs in the same cycle, each from its own byte lane. Bytes of other CSRs are left unchanged.
- R6: CSR 0x3B0+i (i=0..15) is the address register of region i. A write stores the full XLEN-bit value, and a later read returns it.
- R7: An access to any CSR number outside the implemented set raises illegal_csr for exactly the following cycle, returns zero read data and changes no stored state.
- R8: Read data and the illegal flag appear in the cycle after the access. The read data is the register value from before that access's write, and both are zero after a cycle with no access.
- R9: ent_rperm[i] equals bit 0 of region i's stored configuration byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | An access is presented this cycle |
| csr_we | input | 1 | The access writes |
| csr_addr | input | 12 | CSR number |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Previous register value, one cycle after the access |
| illegal_csr | output | 1 | Access hit an unimplemented CSR number, one cycle after |
| ent_cfg | output | 128 | Configuration byte of region i in bits [8i+7:8i] |
| ent_addr | output | 16*XLEN | Address register of region i in slice i |
| ent_rperm | output | 16 | Read-permission bit of each region |

## Verification
A wrong lane or group decode shows on the parallel ent_cfg outputs in the cycle right after the offending write. It shows on csr_rdata in the cycle after any read of the affected CSR. A missed decode of an unimplemented number either fails to raise illegal_csr one cycle after the access or leaks a stored byte into the read data. A stray write into state appears on the parallel outputs at once. The reference model compares both word widths on every cycle, so any divergence is reported within one clock of its cause.

// File: rtl/pmp_csr_file.sv
module pmp_csr_file #(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_req,
  input  logic               csr_we,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               illegal_csr,
  output logic [16*8-1:0]    ent_cfg,
  output logic [16*XLEN-1:0] ent_addr,
  output logic [15:0]        ent_rperm
);

  localparam int NENT  = 16;
  localparam int LANES = XLEN / 8;
  localparam logic [11:0] CFG_BASE = 12'h3A0;
  localparam logic [11:0] ADR_BASE = 12'h3B0;

  logic [NENT-1:0][7:0]      cfg_q;
  logic [NENT-1:0][XLEN-1:0] adr_q;

  logic       is_cfg, cfg_ok, is_adr, legal, wr;
  logic [1:0] cfg_idx;
  logic [3:0] adr_idx, grp_base;
  logic [XLEN-1:0] cfg_word, rd_mux;

  assign is_cfg   = csr_addr[11:2] == CFG_BASE[11:2];
  assign cfg_ok   = is_cfg && (XLEN == 32 || !csr_addr[0]);
  assign is_adr   = csr_addr[11:4] == ADR_BASE[11:4];
  assign legal    = cfg_ok || is_adr;
  assign wr       = csr_req && csr_we && legal;
  assign cfg_idx  = csr_addr[1:0];
  assign adr_idx  = csr_addr[3:0];
  assign grp_base = {cfg_idx, 2'b00};

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign cfg_word[8*j +: 8] = cfg_q[grp_base + 4'(j)];
  end

  assign rd_mux = cfg_ok ? cfg_word : (is_adr ? adr_q[adr_idx] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_rdata   <= '0;
      illegal_csr <= 1'b0;
    end else begin
      csr_rdata   <= csr_req ? rd_mux : '0;
      illegal_csr <= csr_req && !legal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr && cfg_ok) begin
      for (int i = 0; i < NENT; i++) begin
        if (grp_base == 4'((i / LANES) * LANES))
          cfg_q[i] <= csr_wdata[8*(i % LANES) +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adr_q <= '0;
    else if (wr && is_adr) adr_q[adr_idx] <= csr_wdata;
  end

  assign ent_cfg  = cfg_q;
  assign ent_addr = adr_q;

  for (genvar i = 0; i < NENT; i++) begin : g_perm
    assign ent_rperm[i] = cfg_q[i][0];
  end

  // R7
  illegal_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_csr |-> csr_rdata == '0);

  // R7
  illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_csr |-> ($stable(ent_cfg) && $stable(ent_addr)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(csr_req) |-> (!illegal_csr && csr_rdata == '0));

  // R6
  addr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csr_req && csr_we && is_adr) |-> adr_q[$past(adr_idx)] == $past(csr_wdata));

  // R5
  cfg_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csr_req && csr_we && cfg_ok) |-> cfg_q[$past(grp_base)] == $past(csr_wdata[7:0]));

endmodule

// File: tb/pmp_csr_file_bench.sv
module pmp_csr_file_bench;
  logic clk = 0;
  always #5 clk = ~clk;

  logic        rst_n = 0;
  logic        req32 = 0, req64 = 0, we = 0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;

  logic [31:0]   rd32;
  logic          ill32;
  logic [127:0]  cfg32o;
  logic [511:0]  adr32o;
  logic [15:0]   rp32;
  logic [63:0]   rd64;
  logic          ill64;
  logic [127:0]  cfg64o;
  logic [1023:0] adr64o;
  logic [15:0]   rp64;

  pmp_csr_file #(.XLEN(32)) u_pmp_csr_file (
    .clk(clk), .rst_n(rst_n), .csr_req(req32), .csr_we(we), .csr_addr(addr),
    .csr_wdata(wdata[31:0]), .csr_rdata(rd32), .illegal_csr(ill32),
    .ent_cfg(cfg32o), .ent_addr(adr32o), .ent_rperm(rp32));

  pmp_csr_file #(.XLEN(64)) u_pmp_csr_file64 (
    .clk(clk), .rst_n(rst_n), .csr_req(req64), .csr_we(we), .csr_addr(addr),
    .csr_wdata(wdata), .csr_rdata(rd64), .illegal_csr(ill64),
    .ent_cfg(cfg64o), .ent_addr(adr64o), .ent_rperm(rp64));

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0]  mc [2][16];
  logic [63:0] ma [2][16];

  task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
    failures++;
    $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
  endtask

  function automatic void model_access(int m, logic w, logic [11:0] a, logic [63:0] d,
                                       output logic [63:0] rd, output logic ill,
                                       output string tag);
    int lanes = (m == 1) ? 8 : 4;
    rd = '0; ill = 0;
    if (a[11:2] == 10'h0E8 && (m == 0 || !a[0])) begin
      int base = int'(a[1:0]) * 4;
      for (int j = 0; j < lanes; j++) rd[8*j +: 8] = mc[m][base + j];
      if (w) for (int j = 0; j < lanes; j++) mc[m][base + j] = d[8*j +: 8];
      tag = w ? "R5" : ((m == 1) ? "R3" : "R2");
    end else if (a[11:4] == 8'h3B) begin
      rd = ma[m][a[3:0]];
      if (w) ma[m][a[3:0]] = (m == 1) ? d : {32'h0, d[31:0]};
      tag = "R6";
    end else begin
      ill = 1;
      tag = (a[11:2] == 10'h0E8) ? "R4" : "R7";
    end
  endfunction

  task automatic check_dut(int m, logic [63:0] erd, logic eill, string tag);
    logic [63:0] ard;
    logic aill;
    bit bad;
    ard  = (m == 1) ? rd64 : {32'h0, rd32};
    aill = (m == 1) ? ill64 : ill32;
    checks++;
    if (ard !== erd) fail_line(tag, "rdata", ard, erd);
    checks++;
    if (aill !== eill) fail_line(tag, "illegal", 64'(aill), 64'(eill));
    checks++;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0]  ac;
      logic [63:0] aa;
      ac = (m == 1) ? cfg64o[8*i +: 8] : cfg32o[8*i +: 8];
      aa = (m == 1) ? adr64o[64*i +: 64] : {32'h0, adr32o[32*i +: 32]};
      if (!bad && ac !== mc[m][i]) begin bad = 1; fail_line(tag, "cfg state", 64'(ac), 64'(mc[m][i])); end
      if (!bad && aa !== ma[m][i]) begin bad = 1; fail_line(tag, "addr state", aa, ma[m][i]); end
    end
    checks++;
    for (int i = 0; i < 16; i++) begin
      logic ap;
      ap = (m == 1) ? rp64[i] : rp32[i];
      if (ap !== mc[m][i][0]) begin
        fail_line("R9", "rperm", 64'(ap), 64'(mc[m][i][0]));
        break;
      end
    end
  endtask

  task automatic step(int m, logic r, logic w, logic [11:0] a, logic [63:0] d);
    logic [63:0] erd;
    logic eill;
    string tag;
    erd = '0; eill = 0; tag = "R8";
    if (r) model_access(m, w, a, d, erd, eill, tag);
    req32 = r && (m == 0);
    req64 = r && (m == 1);
    we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req32 = 0; req64 = 0; we = 0;
    for (int k = 0; k < 2; k++) begin
      if (k == m) check_dut(k, erd, eill, tag);
      else check_dut(k, 64'h0, 1'b0, "R8");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 16; i++) begin mc[m][i] = '0; ma[m][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state of both widths
    check_dut(0, 64'h0, 1'b0, "R1");
    check_dut(1, 64'h0, 1'b0, "R1");

    for (int m = 0; m < 2; m++) begin
      // R2 R3 R4: zero reads, odd numbers illegal on 64-bit
      for (int k = 0; k < 4; k++) step(m, 1, 0, 12'h3A0 + 12'(k), '0);
      // R5: write each config CSR with lane-distinct data, then read back
      for (int k = 0; k < 4; k++)
        step(m, 1, 1, 12'h3A0 + 12'(k), 64'h8170_6152_4334_2519 ^ {8{8'(k * 16 + 3)}});
      for (int k = 0; k < 4; k++) step(m, 1, 0, 12'h3A0 + 12'(k), '0);
      // R5: rewrite one CSR, neighbours keep their bytes; write returns old value (R8)
      step(m, 1, 1, 12'h3A2, 64'hFEDC_BA98_7654_3210);
      step(m, 1, 0, 12'h3A2, '0);
      step(m, 1, 0, 12'h3A0, '0);
      // R4: odd config numbers on 64-bit must not touch state
      step(m, 1, 1, 12'h3A1, 64'hFFFF_FFFF_FFFF_FFFF);
      step(m, 1, 1, 12'h3A3, 64'hFFFF_FFFF_FFFF_FFFF);
      // R6: every address register, full width
      for (int i = 0; i < 16; i++)
        step(m, 1, 1, 12'h3B0 + 12'(i), {32'hA5A5_0000 + 32'(i), 32'h1234_5600 + 32'(i * 7)});
      for (int i = 0; i < 16; i++) step(m, 1, 0, 12'h3B0 + 12'(i), '0);
      // R7: unimplemented numbers
      step(m, 1, 1, 12'h3C0, 64'hDEAD_BEEF_DEAD_BEEF);
      step(m, 1, 1, 12'h39F, 64'hDEAD_BEEF_DEAD_BEEF);
      step(m, 1, 0, 12'h3A4, '0);
      step(m, 1, 1, 12'h000, 64'h1);
      step(m, 1, 0, 12'hBB0, '0);
      // R8: idle cycles after activity
      step(m, 0, 0, 12'h3B0, '0);
      step(m, 0, 1, 12'h3A0, 64'h5);
      // mixed random traffic
      for (int n = 0; n < 400; n++) begin
        int sel;
        logic [11:0] a;
        sel = int'($urandom % 8);
        if (sel < 3) a = 12'h3A0 + 12'($urandom % 4);
        else if (sel < 6) a = 12'h3B0 + 12'($urandom % 16);
        else a = 12'($urandom);
        step(m, ($urandom % 5) != 0, $urandom % 2 == 1, a, {$urandom, $urandom});
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule